// File: doc/BRIEF.md
# Windowed Watchdog Timer

A down-counting watchdog with a six-bit mode register whose control bits can only be set, never cleared by software. Software programs a time-out constant, a warning threshold and a window threshold, and then arms the timer by writing a two-byte key to the feed register. Each accepted feed reloads the counter from the time-out constant. When the count reaches zero the time-out flag is raised. If reset-select has been set, a one-cycle chip-reset request is also issued.

A feed attempt fails in two ways. The two key bytes can be split by some other write, or the key can be completed while the running counter is still above the window threshold. A third fault comes from protect mode. There, reloading the time-out constant is only allowed once the counter has dropped below both thresholds, and an early write is rejected. All three faults raise the time-out flag, just as expiry does.

The warning flag is level-set while the counter is at or below the warning threshold. It drives the warning interrupt only while the timer runs. A lock status output models the clock-keep-alive interlock.

Top module: `win_wdog`

## Requirements
- R1: After reset the mode register (address 0) reads 0, the counter readback (address 5) equals the reset time-out value, and all outputs are low.
- R2: With mode bit 0 (enable) set, a valid feed reloads the counter from the time-out constant (address 1). The counter then decrements by one every clock and cannot be stopped: writing 0 to bit 0 leaves it set and the count moving.
- R3: Mode bits 0, 1 (reset-select), 4 (protect) and 5 (lock) are set by writing 1 and ignore writes of 0 until reset.
- R4: When the running counter steps from 1 to 0, the time-out flag (mode bit 2, output `tof_o`) is set in that same cycle and the counter holds at 0. With reset-select 0, no reset request is issued.
- R5: With reset-select 1, every event that sets the time-out flag causes `rst_req_o` to pulse high for exactly one cycle, on the clock edge where the flag is set.
- R6: Writing the mode register with bit 2 at 0 clears the time-out flag. Writing bit 2 at 1 neither sets nor clears it.
- R7: The warning flag (mode bit 3) is set on the edge after the counter is at or below the warning threshold (address 3). Writing 1 to bit 3 clears it. `warn_irq_o` is the warning flag gated by the running state.
- R8: A write of 1 to mode bit 3 is ignored while the counter equals the warning threshold.
- R9: A feed is a write of 0xAA followed by a write of 0x55 to address 2, with no other write in between. Any other write after 0xAA is a feed error: it sets the time-out flag and the counter is not reloaded.
- R10: A completed key while the timer runs and the counter exceeds the window threshold (address 4) is a feed error: the time-out flag is set and the counter is not reloaded.
- R11: With protect set, a write to the time-out constant takes effect only if the counter is below both the warning and the window thresholds. Otherwise the constant is unchanged and the time-out flag is set.
- R12: `lock_o` rises on the first valid feed after the lock bit is set and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 mode, 1 time-out constant, 2 feed, 3 warning, 4 window |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 3 | Read address: as for writes, plus 5 for the counter |
| rd_data_o | output | CNT_W | Combinational read data |
| warn_irq_o | output | 1 | Warning interrupt |
| tof_o | output | 1 | Time-out flag (time-out interrupt) |
| rst_req_o | output | 1 | One-cycle chip-reset request |
| lock_o | output | 1 | Clock keep-alive lock |

## Verification
The countdown is driven to natural expiry twice, once with reset-select clear and once with it set. This separates a flag-only time-out from the one-cycle reset pulse. Feed keys are tried clean, interrupted by a foreign write, and completed above the window threshold. Only the clean key may reload the counter. The other two cases must leave the count running down with the flag set. Warning clears are issued both when the counter equals the threshold and when it is below it. Time-out constant writes are issued both before and after the counter drops under the protect thresholds. Each pair isolates one gating condition.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
  typedef enum logic [2:0] {
    ADDR_MODE   = 3'd0,
    ADDR_TCONST = 3'd1,
    ADDR_FEED   = 3'd2,
    ADDR_WARN   = 3'd3,
    ADDR_WINDOW = 3'd4,
    ADDR_COUNT  = 3'd5
  } wd_addr_e;

  localparam int unsigned MODE_W  = 6;
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_RSTEN = 1;
  localparam int unsigned B_TOF   = 2;
  localparam int unsigned B_WINT  = 3;
  localparam int unsigned B_PROT  = 4;
  localparam int unsigned B_LOCK  = 5;

  // bits that software can only set
  localparam logic [MODE_W-1:0] STICKY_MASK = 6'b110011;

  localparam logic [7:0] KEY_ARM  = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;
endpackage

// File: rtl/win_wdog_feed.sv
module win_wdog_feed
  import win_wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       is_feed_i,
  input  logic [7:0] key_i,
  output logic       done_o,
  output logic       err_o
);
  logic armed_q;
  logic hit_arm, hit_fire;

  assign hit_arm  = wr_en_i & is_feed_i & (key_i == KEY_ARM);
  assign hit_fire = wr_en_i & is_feed_i & (key_i == KEY_FIRE);
  assign done_o   = armed_q & hit_fire;
  assign err_o    = armed_q & wr_en_i & ~hit_fire;

  // once armed, the very next write either completes or aborts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= ~armed_q & hit_arm;
  end
endmodule

// File: rtl/win_wdog_cnt.sv
module win_wdog_cnt #(
  parameter int unsigned      CNT_W  = 16,
  parameter logic [CNT_W-1:0] TC_RST = 16'h00FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = run_i & ~load_i & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= TC_RST;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/win_wdog_mode.sv
module win_wdog_mode
  import win_wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] data_i,
  input  logic              tof_set_i,
  input  logic              warn_hit_i,
  input  logic              warn_eq_i,
  input  logic              feed_ok_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              running_o,
  output logic              lock_o
);
  logic running_q, lock_q;

  for (genvar i = 0; i < MODE_W; i++) begin : g_bit
    logic bit_q;
    if (STICKY_MASK[i]) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                bit_q <= 1'b0;
        else if (wr_i && data_i[i]) bit_q <= 1'b1;
      end
    end else if (i == B_TOF) begin : g_tof
      // hardware set wins over write-0 clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 bit_q <= 1'b0;
        else if (tof_set_i)          bit_q <= 1'b1;
        else if (wr_i && !data_i[i]) bit_q <= 1'b0;
      end
    end else begin : g_wint
      // write-1 clear wins unless counter sits on the threshold
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             bit_q <= 1'b0;
        else if (wr_i && data_i[i] && !warn_eq_i) bit_q <= 1'b0;
        else if (warn_hit_i)                     bit_q <= 1'b1;
      end
    end
    assign mode_o[i] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      if (mode_o[B_EN] && feed_ok_i)   running_q <= 1'b1;
      if (mode_o[B_LOCK] && feed_ok_i) lock_q    <= 1'b1;
    end
  end

  assign running_o = running_q;
  assign lock_o    = lock_q;
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int unsigned      CNT_W  = 16,
  parameter logic [CNT_W-1:0] TC_RST = 16'h00FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             warn_irq_o,
  output logic             tof_o,
  output logic             rst_req_o,
  output logic             lock_o
);
  localparam int unsigned PAD_W = CNT_W - MODE_W;

  logic [CNT_W-1:0]  tconst_q, warn_q, window_q, cnt;
  logic [MODE_W-1:0] mode;
  logic wr_mode, tc_wr, wr_feed, wr_warn, wr_window;
  logic feed_done, seq_err, feed_ok, feed_err;
  logic prot_viol, expire, tof_evt, running, lock_act;
  logic warn_hit, warn_eq, below_both;
  logic rst_req_q;

  assign wr_mode   = wr_en_i & (wr_addr_i == ADDR_MODE);
  assign tc_wr     = wr_en_i & (wr_addr_i == ADDR_TCONST);
  assign wr_feed   = wr_en_i & (wr_addr_i == ADDR_FEED);
  assign wr_warn   = wr_en_i & (wr_addr_i == ADDR_WARN);
  assign wr_window = wr_en_i & (wr_addr_i == ADDR_WINDOW);

  assign warn_hit   = cnt <= warn_q;
  assign warn_eq    = cnt == warn_q;
  assign below_both = (cnt < warn_q) & (cnt < window_q);

  assign prot_viol = tc_wr & mode[B_PROT] & ~below_both;
  assign feed_ok   = feed_done & (~running | (cnt <= window_q));
  assign feed_err  = seq_err | (feed_done & ~feed_ok);
  assign tof_evt   = expire | feed_err | prot_viol;

  win_wdog_feed u_feed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .is_feed_i (wr_feed),
    .key_i     (wr_data_i[7:0]),
    .done_o    (feed_done),
    .err_o     (seq_err)
  );

  win_wdog_cnt #(.CNT_W(CNT_W), .TC_RST(TC_RST)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (running),
    .load_i     (feed_ok),
    .load_val_i (tconst_q),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  win_wdog_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_mode),
    .data_i     (wr_data_i[MODE_W-1:0]),
    .tof_set_i  (tof_evt),
    .warn_hit_i (warn_hit),
    .warn_eq_i  (warn_eq),
    .feed_ok_i  (feed_ok),
    .mode_o     (mode),
    .running_o  (running),
    .lock_o     (lock_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tconst_q  <= TC_RST;
      warn_q    <= '0;
      window_q  <= '1;
      rst_req_q <= 1'b0;
    end else begin
      if (tc_wr && !prot_viol) tconst_q <= wr_data_i;
      if (wr_warn)             warn_q   <= wr_data_i;
      if (wr_window)           window_q <= wr_data_i;
      rst_req_q <= tof_evt & mode[B_RSTEN];
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_MODE:   rd_data_o = {{PAD_W{1'b0}}, mode};
      ADDR_TCONST: rd_data_o = tconst_q;
      ADDR_WARN:   rd_data_o = warn_q;
      ADDR_WINDOW: rd_data_o = window_q;
      ADDR_COUNT:  rd_data_o = cnt;
      default:     rd_data_o = '0;
    endcase
  end

  assign warn_irq_o = mode[B_WINT] & running;
  assign tof_o      = mode[B_TOF];
  assign rst_req_o  = rst_req_q;
  assign lock_o     = lock_act;
endmodule

// File: rtl/win_wdog_sva.sv
module win_wdog_sva #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             running,
  input logic             feed_ok,
  input logic             tof_evt,
  input logic             tc_wr,
  input logic             rst_req_o,
  input logic             lock_o,
  input logic             warn_irq_o,
  input logic [5:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] warn_q,
  input logic [CNT_W-1:0] window_q,
  input logic [CNT_W-1:0] tconst_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_run_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |=> running);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !feed_ok && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  assert_en_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode[0] |=> mode[0]);

  assert_rsten_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode[1] |=> mode[1]);

  assert_prot_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode[4] |=> mode[4]);

  assert_lockbit_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode[5] |=> mode[5]);

  assert_zero_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && cnt == '0 && !feed_ok) |=> (cnt == '0));

  assert_rst_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ($past(tof_evt) && $past(mode[1]) && mode[2]));

  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_irq_o |-> (running && mode[3]));

  assert_wint_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[3] && cnt == warn_q) |=> mode[3]);

  assert_prot_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_wr && mode[4] && !(cnt < warn_q && cnt < window_q)) |=> (tconst_q == $past(tconst_q)));

  assert_lock_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);
endmodule

bind win_wdog win_wdog_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .running    (running),
  .feed_ok    (feed_ok),
  .tof_evt    (tof_evt),
  .tc_wr      (tc_wr),
  .rst_req_o  (rst_req_o),
  .lock_o     (lock_o),
  .warn_irq_o (warn_irq_o),
  .mode       (mode),
  .cnt        (cnt),
  .warn_q     (warn_q),
  .window_q   (window_q),
  .tconst_q   (tconst_q)
);

// File: tb/win_wdog_test.sv
module win_wdog_test;
  localparam int unsigned CNT_W = 16;
  localparam logic [2:0] A_MODE = 3'd0, A_TC = 3'd1, A_FEED = 3'd2,
                         A_WARN = 3'd3, A_WIN = 3'd4, A_CNT = 3'd5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [2:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             warn_irq, tof, rst_req, lock;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  win_wdog #(.CNT_W(CNT_W), .TC_RST(16'h00FF)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .warn_irq_o (warn_irq),
    .tof_o      (tof),
    .rst_req_o  (rst_req),
    .lock_o     (lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CNT_W-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic feed();
    wr(A_FEED, 16'h00AA);
    wr(A_FEED, 16'h0055);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    logic [CNT_W-1:0] v;
    do_reset();
    rd(A_MODE, v); chk("R1 mode", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 16'h00FF);
    chk("R1 outputs", {warn_irq, tof, rst_req, lock}, 0);
  endtask

  task automatic t_run_expire();
    logic [CNT_W-1:0] v;
    do_reset();
    wr(A_TC, 16'd10);
    wr(A_MODE, 16'h01);
    feed();
    rd(A_CNT, v); chk("R2 reload", v, 10);
    idle(3);
    rd(A_CNT, v); chk("R2 decrement", v, 7);
    wr(A_MODE, 16'h00);
    rd(A_CNT, v); chk("R2 not stoppable count", v, 6);
    rd(A_MODE, v); chk("R2 enable kept", v & 16'h1, 1);
    idle(6);
    rd(A_CNT, v); chk("R4 reaches zero", v, 0);
    chk("R4 flag", tof, 1);
    chk("R4 no reset request", rst_req, 0);
    idle(2);
    rd(A_CNT, v); chk("R4 holds zero", v, 0);
    chk("R4 no reset later", rst_req, 0);
    wr(A_MODE, 16'h05); chk("R6 write one keeps flag", tof, 1);
    wr(A_MODE, 16'h01); chk("R6 write zero clears", tof, 0);
    wr(A_MODE, 16'h05); chk("R6 write one does not set", tof, 0);
  endtask

  task automatic t_reset_req();
    logic [CNT_W-1:0] v;
    do_reset();
    wr(A_TC, 16'd5);
    wr(A_MODE, 16'h03);
    wr(A_MODE, 16'h01);
    rd(A_MODE, v); chk("R3 reset-select sticky", v, 16'h03);
    feed();
    chk("R5 idle before expiry", rst_req, 0);
    idle(5);
    chk("R5 pulse on expiry", rst_req, 1);
    chk("R5 flag with pulse", tof, 1);
    idle(1);
    chk("R5 single cycle", rst_req, 0);
  endtask

  task automatic t_feed_seq();
    logic [CNT_W-1:0] v;
    do_reset();
    wr(A_TC, 16'd30);
    wr(A_MODE, 16'h01);
    feed();
    idle(5);
    wr(A_FEED, 16'h00AA);
    wr(A_WARN, 16'h0000);
    wr(A_FEED, 16'h0055);
    chk("R9 interrupted key flags", tof, 1);
    rd(A_CNT, v); chk("R9 no reload", v, 22);
    wr(A_MODE, 16'h01);
    feed();
    rd(A_CNT, v); chk("R9 clean key reloads", v, 30);
    chk("R9 clean key no flag", tof, 0);
  endtask

  task automatic t_window();
    logic [CNT_W-1:0] v;
    do_reset();
    wr(A_TC, 16'd30);
    wr(A_WIN, 16'd10);
    wr(A_MODE, 16'h01);
    feed();
    idle(2);
    feed();
    chk("R10 early feed flags", tof, 1);
    rd(A_CNT, v); chk("R10 early feed no reload", v, 26);
    idle(16);
    wr(A_MODE, 16'h01);
    feed();
    rd(A_CNT, v); chk("R10 in-window feed reloads", v, 30);
    chk("R10 in-window no flag", tof, 0);
  endtask

  task automatic t_warning();
    logic [CNT_W-1:0] v;
    do_reset();
    wr(A_WARN, 16'h00FF);
    idle(1);
    rd(A_MODE, v); chk("R7 flag set at threshold", v, 16'h08);
    chk("R7 no irq while stopped", warn_irq, 0);
    wr(A_MODE, 16'h08);
    rd(A_MODE, v); chk("R8 clear ignored when equal", v, 16'h08);
    wr(A_WARN, 16'h0000);
    wr(A_MODE, 16'h08);
    rd(A_MODE, v); chk("R7 clear by write one", v, 0);
    idle(2);
    rd(A_MODE, v); chk("R7 stays clear above threshold", v, 0);
    wr(A_TC, 16'd20);
    wr(A_WARN, 16'd5);
    wr(A_MODE, 16'h01);
    feed();
    idle(15);
    chk("R7 no irq at equal before edge", warn_irq, 0);
    idle(1);
    chk("R7 irq while running", warn_irq, 1);
    wr(A_MODE, 16'h09);
    chk("R7 irq cleared", warn_irq, 0);
    idle(1);
    chk("R7 level re-set below threshold", warn_irq, 1);
  endtask

  task automatic t_protect();
    logic [CNT_W-1:0] v;
    do_reset();
    wr(A_TC, 16'd40);
    wr(A_WARN, 16'd10);
    wr(A_WIN, 16'd20);
    wr(A_MODE, 16'h11);
    feed();
    wr(A_TC, 16'd50);
    rd(A_TC, v); chk("R11 early reload rejected", v, 40);
    chk("R11 violation flags", tof, 1);
    idle(30);
    wr(A_MODE, 16'h01);
    rd(A_MODE, v); chk("R3 protect sticky", v & 16'h10, 16'h10);
    wr(A_TC, 16'd50);
    rd(A_TC, v); chk("R11 late reload accepted", v, 50);
    chk("R11 no flag on accept", tof, 0);
  endtask

  task automatic t_lock();
    logic [CNT_W-1:0] v;
    do_reset();
    wr(A_MODE, 16'h20);
    chk("R12 no lock before feed", lock, 0);
    feed();
    chk("R12 lock after feed", lock, 1);
    wr(A_MODE, 16'h00);
    chk("R12 lock held", lock, 1);
    rd(A_MODE, v); chk("R3 lock bit sticky", v & 16'h20, 16'h20);
  endtask

  initial begin
    t_reset();
    t_run_expire();
    t_reset_req();
    t_feed_seq();
    t_window();
    t_warning();
    t_protect();
    t_lock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule